// File: doc/BRIEF.md
# Code-Protected Watchdog Timer

A watchdog built around a free-running binary counter. The counter advances once for every system-clock cycle in which the prescale input `tick` is high. A 2-bit period field picks one of four overflow points. The overflow points are spaced by a factor of four, and the field value 0 gives the longest one. At each overflow the block does one of two things, chosen by a single action bit. It either raises a non-maskable interrupt request that stays up until the processor accepts it, or it starts an internal reset request pulse of fixed length.

Software configures the block through a byte-wide write port with two registers. The configuration register holds the enable, period and action fields. The command register does not store anything; it only recognises two code bytes. The restart code 0xB1 sets the counter back to zero. The stop code 0x4E halts the watchdog, but only if the enable bit was cleared in an earlier write. So neither a single stray write to the configuration register nor a single stray code byte can silence the watchdog.

The interrupt path follows the processor's service of the interrupt. `irq_ack` marks that the request was taken, and `irq_ret` marks the end of the service routine. If an overflow occurs while a service routine is still running, a new request is held back until `irq_ret` arrives.

Top module: `wdt_guard`

The gate state machine has three states:
- GATE_RUN: counting.
- GATE_ARMED: the enable bit has been cleared; still counting.
- GATE_STOPPED: halted, counter held at zero.

Its transitions:
- RUN to ARMED on a configuration write with enable 0.
- ARMED to RUN on a configuration write with enable 1.
- ARMED to STOPPED on a stop code.
- STOPPED to RUN on a configuration write with enable 1.

The event state machine has five states:
- EV_IDLE
- EV_IRQ (request raised)
- EV_SERVICE (request accepted)
- EV_SERV_PEND (accepted, with a further overflow waiting)
- EV_RESET (pulse running)

Its transitions:
- IDLE to IRQ or RESET on an overflow, chosen by the action bit.
- IRQ to SERVICE on `irq_ack`.
- SERVICE to IDLE on `irq_ret`.
- SERVICE to SERV_PEND on an overflow.
- SERV_PEND to IRQ on `irq_ret`.
- Any state except RESET goes to RESET on an overflow when the action is reset.
- RESET to IDLE when the pulse length has elapsed.

## Requirements
- R1: After reset both outputs are low and the watchdog is running, with action = reset and period field = 0. Its first event is therefore a reset pulse 2^(TAP_BASE+6) ticks after reset release.
- R2: The period field is configuration-register bits [2:1] with value p. An event occurs exactly 2^(TAP_BASE+6-2p) ticks after the last counter restart.
- R3: The counter advances only in cycles where `tick` is high. Cycles with `tick` low do not move it toward overflow.
- R4: Configuration-register bit 3 selects the action: 0 for an interrupt request, 1 for a reset request. A reset request stays high for exactly 2^RST_LOG2 + RST_EXTRA clock cycles.
- R5: `irq_req` stays high until `irq_ack` is sampled high. It is low in the following cycle.
- R6: An overflow between `irq_ack` and `irq_ret` does not raise `irq_req` at once. `irq_req` rises in the cycle after `irq_ret`.
- R7: Writing 0xB1 to the command register (address 1) restarts the count from zero. Restarting at least once per period prevents any event.
- R8: Writing any byte other than 0xB1 or 0x4E to the command register leaves the count unchanged.
- R9: Writing 0x4E while the enable bit (configuration bit 0) is still 1 has no effect, and the watchdog still times out on schedule.
- R10: A configuration write with enable 0 followed by 0x4E stops the watchdog, and no event occurs afterwards. A later configuration write with enable 1 restarts it with the count starting from zero.
- R11: A configuration write with enable 0 on its own does not stop counting.
- R12: `irq_req` and `rst_req` are never high together. A reset-action overflow takes priority over an interrupt that is outstanding, and drops that interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = configuration register, 1 = command register |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | Processor accepted the interrupt |
| irq_ret | input | 1 | Interrupt service routine finished |
| irq_req | output | 1 | Non-maskable interrupt request |
| rst_req | output | 1 | Internal reset request pulse |

## Verification
Each of the four period codes is timed from a restart to the exact clock cycle of its event. This separates the four overflow points from each other and catches a tap that is off by one bit or off by one cycle. The command register is driven with the restart code repeated faster than the period, with stray bytes, and with the stop code both with and without the enable bit cleared first. These cases separate a real restart from an ignored write, and a two-step stop from a rejected one-step stop. Holding `tick` low, and moving the acknowledge and return inputs around a second overflow, shows that the counter is gated by the prescale input and that a new interrupt is held back during service. Switching the action bit while an interrupt is outstanding exposes the priority of reset over interrupt.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    typedef enum logic [1:0] {
        GATE_RUN     = 2'd0,
        GATE_ARMED   = 2'd1,
        GATE_STOPPED = 2'd2
    } gate_state_t;

    typedef enum logic [2:0] {
        EV_IDLE      = 3'd0,
        EV_IRQ       = 3'd1,
        EV_SERVICE   = 3'd2,
        EV_SERV_PEND = 3'd3,
        EV_RESET     = 3'd4
    } ev_state_t;

    localparam logic [7:0] CODE_RESTART = 8'hB1;
    localparam logic [7:0] CODE_STOP    = 8'h4E;

    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_SEL_LO  = 1;
    localparam int CFG_ACT_BIT = 3;

    localparam logic       ADDR_CFG = 1'b0;
    localparam logic       ADDR_CMD = 1'b1;

endpackage

// File: rtl/wdt_guard_regs.sv
module wdt_guard_regs
    import wdt_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [7:0]  wr_data,
    output logic        run,
    output logic        cnt_clr,
    output logic [1:0]  sel,
    output logic        act_rst,
    output gate_state_t gate_st
);

    gate_state_t gate_nx;
    logic        cfg_wr;
    logic        cmd_wr;
    logic        restart_hit;
    logic        stop_hit;

    assign cfg_wr      = wr_en && (wr_addr == ADDR_CFG);
    assign cmd_wr      = wr_en && (wr_addr == ADDR_CMD);
    assign restart_hit = cmd_wr && (wr_data == CODE_RESTART);
    assign stop_hit    = cmd_wr && (wr_data == CODE_STOP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_st <= GATE_RUN;
        end else begin
            gate_st <= gate_nx;
        end
    end

    // next state
    always_comb begin
        gate_nx = gate_st;
        unique case (gate_st)
            GATE_RUN: begin
                if (cfg_wr && !wr_data[CFG_EN_BIT]) begin
                    gate_nx = GATE_ARMED;
                end
            end
            GATE_ARMED: begin
                if (cfg_wr && wr_data[CFG_EN_BIT]) begin
                    gate_nx = GATE_RUN;
                end else if (stop_hit) begin
                    gate_nx = GATE_STOPPED;
                end
            end
            GATE_STOPPED: begin
                if (cfg_wr && wr_data[CFG_EN_BIT]) begin
                    gate_nx = GATE_RUN;
                end
            end
            default: gate_nx = GATE_RUN;
        endcase
    end

    // configuration fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel     <= 2'b00;
            act_rst <= 1'b1;
        end else if (cfg_wr) begin
            sel     <= wr_data[CFG_SEL_LO +: 2];
            act_rst <= wr_data[CFG_ACT_BIT];
        end
    end

    // outputs
    always_comb begin
        run     = (gate_st != GATE_STOPPED);
        cnt_clr = restart_hit || (stop_hit && (gate_st == GATE_ARMED));
    end

endmodule

// File: rtl/wdt_guard_counter.sv
module wdt_guard_counter #(
    parameter int TAP_BASE = 19,
    parameter int N_TAPS   = 4,
    parameter int TAP_STEP = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               tick,
    input  logic                               run,
    input  logic                               clr,
    input  logic                               hold,
    input  logic [1:0]                         sel,
    output logic                               ovf,
    output logic [TAP_BASE+TAP_STEP*(N_TAPS-1)-1:0] cnt
);

    localparam int CW = TAP_BASE + TAP_STEP * (N_TAPS - 1);

    logic [CW-1:0] term [N_TAPS];

    // terminal count of each tap: all ones, shortened by TAP_STEP bits per step
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        assign term[g] = {CW{1'b1}} >> (TAP_STEP * g);
    end

    assign ovf = tick && run && !clr && !hold && (cnt >= term[sel]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || hold || !run) begin
            cnt <= '0;
        end else if (tick) begin
            if (ovf) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_guard_event.sv
module wdt_guard_event
    import wdt_guard_pkg::*;
#(
    parameter int RST_LEN = 1040
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ovf,
    input  logic      act_rst,
    input  logic      irq_ack,
    input  logic      irq_ret,
    output logic      irq_req,
    output logic      rst_req,
    output logic      in_reset,
    output ev_state_t ev_st
);

    localparam int RCW = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;

    ev_state_t      ev_nx;
    logic [RCW-1:0] rcnt;
    logic           rst_ovf;
    logic           irq_ovf;
    logic           pulse_done;

    assign rst_ovf    = ovf && act_rst;
    assign irq_ovf    = ovf && !act_rst;
    assign pulse_done = (rcnt == RCW'(RST_LEN - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_st <= EV_IDLE;
        end else begin
            ev_st <= ev_nx;
        end
    end

    // pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt <= '0;
        end else if (ev_st == EV_RESET) begin
            rcnt <= rcnt + 1'b1;
        end else begin
            rcnt <= '0;
        end
    end

    // next state
    always_comb begin
        ev_nx = ev_st;
        unique case (ev_st)
            EV_IDLE: begin
                if (rst_ovf) begin
                    ev_nx = EV_RESET;
                end else if (irq_ovf) begin
                    ev_nx = EV_IRQ;
                end
            end
            EV_IRQ: begin
                if (rst_ovf) begin
                    ev_nx = EV_RESET;
                end else if (irq_ack) begin
                    ev_nx = EV_SERVICE;
                end
            end
            EV_SERVICE: begin
                if (rst_ovf) begin
                    ev_nx = EV_RESET;
                end else if (irq_ret) begin
                    ev_nx = irq_ovf ? EV_IRQ : EV_IDLE;
                end else if (irq_ovf) begin
                    ev_nx = EV_SERV_PEND;
                end
            end
            EV_SERV_PEND: begin
                if (rst_ovf) begin
                    ev_nx = EV_RESET;
                end else if (irq_ret) begin
                    ev_nx = EV_IRQ;
                end
            end
            EV_RESET: begin
                if (pulse_done) begin
                    ev_nx = EV_IDLE;
                end
            end
            default: ev_nx = EV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_req  = (ev_st == EV_IRQ);
        rst_req  = (ev_st == EV_RESET);
        in_reset = (ev_st == EV_RESET);
    end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int TAP_BASE  = 19,
    parameter int RST_LOG2  = 10,
    parameter int RST_EXTRA = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       irq_ack,
    input  logic       irq_ret,
    output logic       irq_req,
    output logic       rst_req
);

    localparam int N_TAPS   = 4;
    localparam int TAP_STEP = 2;
    localparam int CW       = TAP_BASE + TAP_STEP * (N_TAPS - 1);
    localparam int RST_LEN  = (1 << RST_LOG2) + RST_EXTRA;

    logic          run;
    logic          cnt_clr;
    logic [1:0]    sel;
    logic          act_rst;
    gate_state_t   gate_st;
    logic          ovf;
    logic [CW-1:0] cnt_val;
    logic          in_reset;
    ev_state_t     ev_st;

    wdt_guard_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run     (run),
        .cnt_clr (cnt_clr),
        .sel     (sel),
        .act_rst (act_rst),
        .gate_st (gate_st)
    );

    wdt_guard_counter #(
        .TAP_BASE (TAP_BASE),
        .N_TAPS   (N_TAPS),
        .TAP_STEP (TAP_STEP)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (run),
        .clr   (cnt_clr),
        .hold  (in_reset),
        .sel   (sel),
        .ovf   (ovf),
        .cnt   (cnt_val)
    );

    wdt_guard_event #(
        .RST_LEN (RST_LEN)
    ) u_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf      (ovf),
        .act_rst  (act_rst),
        .irq_ack  (irq_ack),
        .irq_ret  (irq_ret),
        .irq_req  (irq_req),
        .rst_req  (rst_req),
        .in_reset (in_reset),
        .ev_st    (ev_st)
    );

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
    import wdt_guard_pkg::*;
#(
    parameter int CW      = 25,
    parameter int RST_LEN = 1040
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_addr,
    input logic [7:0]    wr_data,
    input logic          irq_req,
    input logic          irq_ack,
    input logic          rst_req,
    input logic          ovf,
    input logic          act_rst,
    input gate_state_t   gate_st,
    input logic [CW-1:0] cnt_val
);

    int unsigned width_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= 0;
        end else if (rst_req) begin
            width_q <= width_q + 1;
        end else begin
            width_q <= 0;
        end
    end

    AST_EXCLUSIVE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_req && rst_req)); // R12

    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (width_q == RST_LEN)); // R4

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack && !(ovf && act_rst)) |=> irq_req); // R5

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && wr_data == CODE_RESTART) |=> (cnt_val == '0)); // R7

    AST_LONE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && wr_data == CODE_STOP && gate_st == GATE_RUN)
        |=> (gate_st == GATE_RUN)); // R9

    AST_ARM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && !wr_data[CFG_EN_BIT] && gate_st == GATE_RUN)
        |=> (gate_st == GATE_ARMED)); // R11

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_st == GATE_STOPPED) |-> !ovf); // R10

endmodule

bind wdt_guard wdt_guard_chk #(
    .CW      (TAP_BASE + 6),
    .RST_LEN ((1 << RST_LOG2) + RST_EXTRA)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq_req (irq_req),
    .irq_ack (irq_ack),
    .rst_req (rst_req),
    .ovf     (ovf),
    .act_rst (act_rst),
    .gate_st (gate_st),
    .cnt_val (cnt_val)
);

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;

    localparam int TAP_BASE  = 2;
    localparam int RST_LOG2  = 3;
    localparam int RST_EXTRA = 2;
    localparam int RST_LEN   = (1 << RST_LOG2) + RST_EXTRA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       irq_req;
    logic       rst_req;

    int n_checks = 0;
    int n_fails  = 0;
    int n_both   = 0;

    always #4 clk = ~clk;

    wdt_guard #(
        .TAP_BASE  (TAP_BASE),
        .RST_LOG2  (RST_LOG2),
        .RST_EXTRA (RST_EXTRA)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq_ack (irq_ack),
        .irq_ret (irq_ret),
        .irq_req (irq_req),
        .rst_req (rst_req)
    );

    always @(negedge clk) begin
        if (rst_n && irq_req && rst_req) n_both++;
    end

    function automatic int period(input int p);
        return 1 << (TAP_BASE + 6 - 2 * p);
    endfunction

    function automatic logic [7:0] cfg(input bit en, input int p, input bit act);
        return {4'b0000, act, 2'(p), en};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        irq_ack = 1'b0;
        irq_ret = 1'b0;
        tick    = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic prep(input int p, input bit act, input bit en);
        wr(1'b1, 8'hB1);
        wr(1'b0, cfg(en, p, act));
        wr(1'b1, 8'hB1);
    endtask

    // n edges after the current point: quiet for n-1, event on the n-th
    task automatic expect_after(input int n, input bit want_rst, input string req);
        bit quiet = 1'b1;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (irq_req || rst_req) quiet = 1'b0;
        end
        check(quiet, req, int'(!quiet), 0);
        @(negedge clk);
        if (want_rst) check(rst_req === 1'b1, req, int'(rst_req), 1);
        else          check(irq_req === 1'b1 && rst_req === 1'b0, req, int'(irq_req), 1);
    endtask

    task automatic t_reset_defaults();
        int width;
        do_reset();
        check(irq_req === 1'b0, "R1 irq_req after reset", int'(irq_req), 0);
        check(rst_req === 1'b0, "R1 rst_req after reset", int'(rst_req), 0);
        expect_after(period(0), 1'b1, "R1 default reset timeout");
        width = 1;
        for (int i = 0; i < 100 && rst_req; i++) begin
            @(negedge clk);
            if (rst_req) width++;
        end
        check(width == RST_LEN, "R4 reset pulse width", width, RST_LEN);
    endtask

    task automatic t_periods();
        for (int p = 0; p < 4; p++) begin
            do_reset();
            prep(p, 1'b0, 1'b1);
            expect_after(period(p), 1'b0, "R2 period select / R4 irq action");
            irq_ack = 1'b1;
            @(negedge clk);
            irq_ack = 1'b0;
            check(irq_req === 1'b0, "R5 drop after ack", int'(irq_req), 0);
        end
    endtask

    task automatic t_tick_gate();
        bit quiet = 1'b1;
        do_reset();
        wr(1'b1, 8'hB1);
        wr(1'b0, cfg(1'b1, 2, 1'b0));
        tick = 1'b0;
        wr(1'b1, 8'hB1);
        repeat (50) begin
            @(negedge clk);
            if (irq_req || rst_req) quiet = 1'b0;
        end
        check(quiet, "R3 no progress without tick", int'(!quiet), 0);
        tick = 1'b1;
        expect_after(period(2), 1'b0, "R3 count resumes with tick");
    endtask

    task automatic t_irq_service();
        bit held = 1'b1;
        bit low  = 1'b1;
        do_reset();
        prep(3, 1'b0, 1'b1);
        expect_after(period(3), 1'b0, "R2 shortest period");
        repeat (20) begin
            @(negedge clk);
            if (!irq_req) held = 1'b0;
        end
        check(held, "R5 irq_req held until ack", int'(held), 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check(irq_req === 1'b0, "R5 ack clears request", int'(irq_req), 0);
        repeat (10) begin
            @(negedge clk);
            if (irq_req) low = 1'b0;
        end
        check(low, "R6 overflow in service held back", int'(!low), 0);
        irq_ret = 1'b1;
        @(negedge clk);
        irq_ret = 1'b0;
        check(irq_req === 1'b1, "R6 request after return", int'(irq_req), 1);
    endtask

    task automatic t_restart();
        bit quiet = 1'b1;
        do_reset();
        prep(3, 1'b0, 1'b1);
        for (int i = 0; i < 30; i++) begin
            wr(1'b1, 8'hB1);
            @(negedge clk);
            if (irq_req || rst_req) quiet = 1'b0;
            @(negedge clk);
            if (irq_req || rst_req) quiet = 1'b0;
        end
        check(quiet, "R7 periodic restart prevents event", int'(!quiet), 0);
        expect_after(2, 1'b0, "R7 count from last restart");
    endtask

    task automatic t_stray_codes();
        do_reset();
        prep(2, 1'b0, 1'b1);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hB0);
        expect_after(period(2) - 2, 1'b0, "R8 stray command bytes ignored");
    endtask

    task automatic t_lone_stop();
        do_reset();
        prep(2, 1'b0, 1'b1);
        wr(1'b1, 8'h4E);
        expect_after(period(2) - 1, 1'b0, "R9 stop code without arming ignored");
    endtask

    task automatic t_arm_only();
        do_reset();
        prep(2, 1'b0, 1'b0);
        expect_after(period(2), 1'b0, "R11 enable cleared alone keeps counting");
    endtask

    task automatic t_two_step_stop();
        bit quiet = 1'b1;
        do_reset();
        prep(2, 1'b1, 1'b0);
        wr(1'b1, 8'h4E);
        repeat (300) begin
            @(negedge clk);
            if (irq_req || rst_req) quiet = 1'b0;
        end
        check(quiet, "R10 two-step stop silences watchdog", int'(!quiet), 0);
        wr(1'b0, cfg(1'b1, 2, 1'b0));
        expect_after(period(2), 1'b0, "R10 re-enable counts from zero");
    endtask

    task automatic t_reset_priority();
        bit seen = 1'b0;
        bit irq_at_rst = 1'b0;
        do_reset();
        prep(3, 1'b0, 1'b1);
        expect_after(period(3), 1'b0, "R12 interrupt outstanding");
        wr(1'b0, cfg(1'b1, 3, 1'b1));
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (rst_req) begin
                seen = 1'b1;
                irq_at_rst = irq_req;
            end
        end
        check(seen && !irq_at_rst, "R12 reset overrides pending interrupt", int'(seen), 1);
        repeat (RST_LEN + 1) @(negedge clk);
        check(irq_req === 1'b0, "R12 interrupt dropped by reset", int'(irq_req), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        t_reset_defaults();
        t_periods();
        t_tick_gate();
        t_irq_service();
        t_restart();
        t_stray_codes();
        t_lone_stop();
        t_arm_only();
        t_two_step_stop();
        t_reset_priority();
        check(n_both == 0, "R12 outputs never high together", n_both, 0);
        summary_and_end();
    end

endmodule